// File: doc/BRIEF.md
# Serial Character Transmitter with Hardware Flow Control

This block turns a stream of characters into an asynchronous serial line. Each character arrives on a ready/valid input together with a kind code. A data character is framed as a start bit, the data bits least significant first, an optional parity bit and one or two stop bits. Instead of data, the input can ask for an idle character, which holds the line at mark for one whole character time, or a break, which holds it at space. Every bit lasts from one pulse of the bit-time strobe to the next. The strobe comes from an external baud generator.

Flow control works in both directions. When CTS gating is on, a character does not start until the clear-to-send input allows it. The line stays at mark while it waits. A character that has already started always finishes. The CTS value can be taken fresh at each character start, or held from the last cycle in which nothing was being shifted. When RTS control is on, the RTS output is asserted one bit time before the first start bit of a burst. It is released one bit time after the last stop bit of that burst. Its active level can be programmed. The final line level can be inverted. A completion flag reports that nothing is being shifted and nothing is waiting.

Top module: `uart_tx_flow`

## Requirements
- R1: With no inversion, TXD rests at 1. A data character is sent as a 0 start bit, then `DATA_W` data bits starting with bit 0, then any parity bit, then the stop bits at 1. Each bit begins on a clock edge where `bit_tick` is 1 and lasts until the next such edge. TXD never changes on an edge where `bit_tick` is 0.
- R2: With `cfg_parity_en` = 1, a parity bit follows the data. For even parity (`cfg_parity_odd` = 0) it is the XOR of the data bits. For odd parity it is the complement of that XOR.
- R3: `cfg_two_stop` = 0 sends one stop bit and `cfg_two_stop` = 1 sends two.
- R4: There is a single holding slot. `in_ready` = 1 exactly when the slot is empty. A character is taken on a clock edge where `in_valid` and `in_ready` are both 1. If a character waits in the slot when a frame ends, and nothing blocks it, its start bit begins on the same bit edge on which the last stop bit ends.
- R5: With `cfg_cts_en` = 1, a character starts only on a bit edge where CTS allows it. While it waits, TXD stays at mark. Once a character has started, changes on `cts_in` do not shorten, stop or alter it. `cts_in` = 1 means clear to send.
- R6: With `cfg_cts_idle_only` = 0, the gate uses `cts_in` as it is on the start edge. With `cfg_cts_idle_only` = 1, the gate uses the value of `cts_in` captured on the last edge at which no frame was being shifted. A character that follows another without a gap is therefore not held back by a CTS drop during the earlier one.
- R7: With `cfg_rts_en` = 1, RTS becomes active on the bit edge one bit time before the first start bit. This is the first start bit of a burst that begins with the slot being filled while RTS is inactive.
- R8: RTS stays active across back-to-back characters and while a character waits for CTS. It becomes inactive one bit time after the last stop bit, when the slot is still empty.
- R9: `cfg_rts_high` = 1 makes RTS active-high and `cfg_rts_high` = 0 makes it active-low. With `cfg_rts_en` = 0, RTS is held at its inactive level.
- R10: `in_kind` = 2 or 3 requests a break. A break holds TXD at space for `DATA_W` + 2 bit times, plus 1 with parity enabled, plus 3 more with `cfg_long_break` = 1. For 8-bit data without parity this is 10 or 13 bit times.
- R11: `in_kind` = 1 requests an idle character. It holds TXD at mark for as many bit times as a data frame with the same settings. `in_kind` = 0 requests data.
- R12: `cfg_tx_invert` = 1 inverts TXD at all times, including the resting level.
- R13: `tx_done` = 1 exactly when no frame is being shifted and the slot is empty. After reset, TXD is at mark, RTS is inactive, `in_ready` = 1 and `tx_done` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe marking each bit boundary |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding slot empty |
| in_data | input | DATA_W | Character data |
| in_kind | input | 2 | 0 data, 1 idle, 2 or 3 break |
| cts_in | input | 1 | Clear to send, 1 = allowed |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | Odd parity when 1 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_long_break | input | 1 | Break lengthened by 3 bit times |
| cfg_tx_invert | input | 1 | Invert TXD |
| cfg_cts_en | input | 1 | Gate character starts on CTS |
| cfg_cts_idle_only | input | 1 | Take CTS only while nothing is shifting |
| cfg_rts_en | input | 1 | Drive RTS around bursts |
| cfg_rts_high | input | 1 | RTS active level is 1 |
| txd | output | 1 | Serial output |
| rts | output | 1 | Request to send |
| tx_done | output | 1 | Nothing shifting and nothing waiting |

## Verification
The bench runs a behavioural model of the line and compares TXD, RTS, `in_ready` and `tx_done` on every clock. It targets these cases:
- Back-to-back characters. A design with a gap bit between frames would show a mark cycle where the next start bit should be.
- CTS dropping inside a frame, in both sampling modes. A design that re-sampled in idle-only mode would stall the second character.
- The RTS lead and tail. A design that drops RTS on the edge where the stop bit ends would lose the trailing bit time.
- Break length, measured as a run of space level in both lengths. An off-by-one counter shows up as a run one bit time short or long.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    typedef enum logic [1:0] {
        KIND_DATA  = 2'd0,
        KIND_IDLE  = 2'd1,
        KIND_BREAK = 2'd2,
        KIND_BRK_B = 2'd3
    } kind_e;

    typedef struct packed {
        logic parity_en;
        logic parity_odd;
        logic two_stop;
        logic long_break;
    } fmt_t;

    typedef struct packed {
        logic cts_en;
        logic cts_idle_only;
        logic rts_en;
    } flow_t;

    localparam int unsigned LONG_BREAK_EXTRA = 3;

    function automatic bit is_break(kind_e k);
        return (k == KIND_BREAK) || (k == KIND_BRK_B);
    endfunction

    // number of bit times a frame of the given kind occupies
    function automatic int unsigned frame_len(fmt_t f, kind_e k, int unsigned dw);
        int unsigned n;
        n = 1 + dw + (f.parity_en ? 1 : 0);
        if (is_break(k))
            n = n + 1 + (f.long_break ? LONG_BREAK_EXTRA : 0);
        else
            n = n + 1 + (f.two_stop ? 1 : 0);
        return n;
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_txf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  kind_e             in_kind,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output kind_e             kind
);

    logic full_q;
    logic [DATA_W-1:0] data_q;
    kind_e kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
            kind_q <= KIND_DATA;
        end else if (!full_q && in_valid) begin
            full_q <= 1'b1;
            data_q <= in_data;
            kind_q <= in_kind;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign full = full_q;
    assign data = data_q;
    assign kind = kind_q;

    // R4: a stored character is kept until the shifter takes it
    assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        full_q && !take |=> full_q);

    // R4: an offered character is stored when the slot is free
    assert_hold_accepts_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && !full_q |=> full_q);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_txf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  kind_e             kind,
    input  fmt_t              fmt,
    output logic              line,
    output logic              busy,
    output logic              frame_end
);

    localparam int unsigned FRAME_W = DATA_W + 6;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] seq;
    logic [CNT_W-1:0]   seq_len;
    logic               par_bit;

    logic               line_q;
    logic               busy_q;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;

    always_comb begin
        par_bit = (^data) ^ fmt.parity_odd;
        seq_len = CNT_W'(frame_len(fmt, kind, DATA_W));
        if (is_break(kind)) begin
            seq = '0;
        end else if (kind == KIND_IDLE) begin
            seq = '1;
        end else begin
            seq = '1;
            seq[0] = 1'b0;
            seq[DATA_W:1] = data;
            if (fmt.parity_en)
                seq[DATA_W+1] = par_bit;
        end
    end

    assign frame_end = bit_tick && busy_q && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b1;
            busy_q <= 1'b0;
            sh_q   <= '1;
            left_q <= '0;
        end else if (start) begin
            line_q <= seq[0];
            sh_q   <= {1'b1, seq[FRAME_W-1:1]};
            left_q <= seq_len - CNT_W'(1);
            busy_q <= 1'b1;
        end else if (frame_end) begin
            busy_q <= 1'b0;
            line_q <= 1'b1;
        end else if (bit_tick && busy_q) begin
            line_q <= sh_q[0];
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign line = line_q;
    assign busy = busy_q;

    // R1: the line only moves on bit boundaries
    assert_line_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(line_q));

    // R5: a started frame runs to its last bit whatever CTS does
    assert_frame_completes_R5: assert property (@(posedge clk) disable iff (rst)
        busy_q && !frame_end |=> busy_q);

endmodule

// File: rtl/uart_tx_flow_ctl.sv
module uart_tx_flow_ctl
    import uart_txf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_tick,
    input  logic  busy,
    input  logic  frame_end,
    input  logic  hold_full,
    input  logic  cts_in,
    input  flow_t cfg,
    output logic  start,
    output logic  rts_on
);

    logic rts_on_q;
    logic cts_lat_q;
    logic slot_free;
    logic cts_ok;

    assign slot_free = !busy || frame_end;
    assign cts_ok    = !cfg.cts_en || (cfg.cts_idle_only ? cts_lat_q : cts_in);
    assign start     = bit_tick && slot_free && hold_full
                       && (!cfg.rts_en || rts_on_q) && cts_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            rts_on_q  <= 1'b0;
            cts_lat_q <= 1'b0;
        end else begin
            if (!busy)
                cts_lat_q <= cts_in;
            if (!cfg.rts_en)
                rts_on_q <= 1'b0;
            else if (bit_tick && slot_free && hold_full && !rts_on_q)
                rts_on_q <= 1'b1;
            else if (bit_tick && !busy && !hold_full && rts_on_q)
                rts_on_q <= 1'b0;
        end
    end

    assign rts_on = rts_on_q;

    // R8: RTS is released only on a bit boundary
    assert_rts_release_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !bit_tick && cfg.rts_en |=> !$fell(rts_on_q));

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import uart_txf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        in_kind,
    input  logic              cts_in,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_long_break,
    input  logic              cfg_tx_invert,
    input  logic              cfg_cts_en,
    input  logic              cfg_cts_idle_only,
    input  logic              cfg_rts_en,
    input  logic              cfg_rts_high,
    output logic              txd,
    output logic              rts,
    output logic              tx_done
);

    fmt_t              fmt;
    flow_t             flow;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    kind_e             hold_kind;
    logic              start;
    logic              line;
    logic              busy;
    logic              frame_end;
    logic              rts_on;
    logic              rts_act;

    assign fmt  = '{parity_en: cfg_parity_en, parity_odd: cfg_parity_odd,
                    two_stop: cfg_two_stop, long_break: cfg_long_break};
    assign flow = '{cts_en: cfg_cts_en, cts_idle_only: cfg_cts_idle_only,
                    rts_en: cfg_rts_en};

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_kind  (kind_e'(in_kind)),
        .take     (start),
        .full     (hold_full),
        .data     (hold_data),
        .kind     (hold_kind)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .start     (start),
        .data      (hold_data),
        .kind      (hold_kind),
        .fmt       (fmt),
        .line      (line),
        .busy      (busy),
        .frame_end (frame_end)
    );

    uart_tx_flow_ctl u_flow (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .busy      (busy),
        .frame_end (frame_end),
        .hold_full (hold_full),
        .cts_in    (cts_in),
        .cfg       (flow),
        .start     (start),
        .rts_on    (rts_on)
    );

    assign rts_act  = cfg_rts_en && rts_on;
    assign rts      = cfg_rts_high ? rts_act : !rts_act;
    assign txd      = line ^ cfg_tx_invert;
    assign in_ready = !hold_full;
    assign tx_done  = !busy && !hold_full;

    // R13: when complete, the uninverted line rests at mark
    assert_done_means_mark_R13: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> line);

    // R7: a frame never begins without RTS already raised
    assert_rts_leads_frame_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) && $past(cfg_rts_en) |-> $past(rts_on));

endmodule

// File: tb/test_uart_tx_flow.sv
module test_uart_tx_flow;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int W          = 8;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [W-1:0] in_data = '0;
    logic [1:0] in_kind = 2'd0;
    logic cts_in = 1'b1;
    logic cfg_parity_en = 0, cfg_parity_odd = 0, cfg_two_stop = 0, cfg_long_break = 0;
    logic cfg_tx_invert = 0, cfg_cts_en = 0, cfg_cts_idle_only = 0;
    logic cfg_rts_en = 0, cfg_rts_high = 0;
    logic txd, rts, tx_done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string tag = "R13";

    uart_tx_flow #(.DATA_W(W)) i_uart_tx_flow (
        .clk(clk), .rst(rst), .bit_tick(bit_tick),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_kind(in_kind),
        .cts_in(cts_in),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_long_break(cfg_long_break),
        .cfg_tx_invert(cfg_tx_invert), .cfg_cts_en(cfg_cts_en),
        .cfg_cts_idle_only(cfg_cts_idle_only), .cfg_rts_en(cfg_rts_en),
        .cfg_rts_high(cfg_rts_high),
        .txd(txd), .rts(rts), .tx_done(tx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference ----------------
    typedef bit bq_t[$];

    function automatic bq_t make_frame(logic [1:0] k, logic [W-1:0] d);
        bq_t q;
        int n;
        if (k >= 2) begin
            n = W + 2 + (cfg_parity_en ? 1 : 0) + (cfg_long_break ? 3 : 0);
            for (int i = 0; i < n; i++) q.push_back(1'b0);
        end else if (k == 1) begin
            n = W + 2 + (cfg_parity_en ? 1 : 0) + (cfg_two_stop ? 1 : 0);
            for (int i = 0; i < n; i++) q.push_back(1'b1);
        end else begin
            int ones = 0;
            q.push_back(1'b0);
            for (int i = 0; i < W; i++) begin
                q.push_back(d[i]);
                if (d[i]) ones++;
            end
            if (cfg_parity_en) q.push_back(((ones % 2) == 1) != cfg_parity_odd);
            q.push_back(1'b1);
            if (cfg_two_stop) q.push_back(1'b1);
        end
        return q;
    endfunction

    bq_t m_bits;
    bit m_full = 0, m_busy = 0, m_line = 1, m_rts = 0, m_lat = 0;
    logic [W-1:0] m_data = '0;
    logic [1:0] m_kind = '0;

    always @(posedge clk) begin
        bit o_full, o_busy, o_rts, endn, free, ok, go;
        if (rst) begin
            m_full = 0; m_busy = 0; m_line = 1; m_rts = 0; m_lat = 0;
            m_bits.delete();
        end else begin
            o_full = m_full; o_busy = m_busy; o_rts = m_rts;
            endn = bit_tick && o_busy && (m_bits.size() == 0);
            free = !o_busy || endn;
            ok   = !cfg_cts_en || (cfg_cts_idle_only ? m_lat : cts_in);
            go   = bit_tick && free && o_full && (!cfg_rts_en || o_rts) && ok;
            if (go) begin
                m_bits = make_frame(m_kind, m_data);
                m_line = m_bits.pop_front();
                m_busy = 1; m_full = 0;
            end else if (endn) begin
                m_busy = 0; m_line = 1;
            end else if (bit_tick && o_busy) begin
                m_line = m_bits.pop_front();
            end
            if (!cfg_rts_en) m_rts = 0;
            else if (bit_tick && free && o_full && !o_rts) m_rts = 1;
            else if (bit_tick && !o_busy && !o_full && o_rts) m_rts = 0;
            if (!o_busy) m_lat = cts_in;
            if (in_valid && !o_full) begin
                m_full = 1; m_data = in_data; m_kind = in_kind;
            end
        end
    end

    // compare, tick generation, low-run monitor
    int tick_cnt = 0;
    int low_run = 0;
    int last_run = 0;
    bit finished = 0;

    always @(negedge clk) begin
        bit act_rts;
        if (!rst) begin
            act_rts = cfg_rts_en && m_rts;
            chk(tag, "txd", int'(txd), int'(m_line ^ cfg_tx_invert));
            chk(tag, "rts", int'(rts), int'(cfg_rts_high ? act_rts : !act_rts));
            chk(tag, "in_ready", int'(in_ready), int'(!m_full));
            chk(tag, "tx_done", int'(tx_done), int'(!m_busy && !m_full));
            if ((txd ^ cfg_tx_invert) == 1'b0) low_run++;
            else if (low_run > 0) begin last_run = low_run; low_run = 0; end
        end
        tick_cnt = (tick_cnt + 1) % DIV;
        bit_tick = (tick_cnt == DIV - 1);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send(logic [1:0] k, logic [W-1:0] d);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_kind = k; in_data = d;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic drain();
        while (!(tx_done && !m_rts)) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13", "reset txd", int'(txd), 1);
        chk("R13", "reset rts", int'(rts), 1);
        chk("R13", "reset in_ready", int'(in_ready), 1);
        chk("R13", "reset tx_done", int'(tx_done), 1);
        rst = 0;
        repeat (4) @(negedge clk);

        tag = "R1 R4";
        send(0, 8'hA5); send(0, 8'h3C); send(0, 8'h00);
        drain();

        tag = "R2 R3";
        cfg_parity_en = 1; cfg_two_stop = 1;
        send(0, 8'h96); send(0, 8'h07);
        drain();
        cfg_parity_odd = 1; cfg_two_stop = 0;
        send(0, 8'h96); send(0, 8'h01);
        drain();
        cfg_parity_en = 0; cfg_parity_odd = 0;

        tag = "R10";
        send(2, 8'h00);
        drain();
        chk("R10", "normal break low cycles", last_run, 10 * DIV);
        cfg_long_break = 1;
        send(3, 8'h00);
        drain();
        chk("R10", "long break low cycles", last_run, 13 * DIV);
        cfg_long_break = 0;

        tag = "R11";
        send(1, 8'hFF); send(0, 8'h55); send(1, 8'h00);
        drain();

        tag = "R12";
        cfg_tx_invert = 1;
        send(0, 8'h0F);
        drain();
        chk("R12", "inverted rest level", int'(txd), 0);
        cfg_tx_invert = 0;

        tag = "R5";
        cfg_cts_en = 1; cts_in = 0;
        send(0, 8'h81);
        repeat (40) @(negedge clk);
        chk("R5", "line held at mark while blocked", int'(txd), 1);
        chk("R5", "not complete while blocked", int'(tx_done), 0);
        cts_in = 1;
        repeat (14) @(negedge clk);
        cts_in = 0;
        repeat (20) @(negedge clk);
        cts_in = 1;
        drain();

        tag = "R6";
        cfg_cts_idle_only = 1; cts_in = 1;
        send(0, 8'h11); send(0, 8'h22);
        repeat (8) @(negedge clk);
        cts_in = 0;
        drain();
        send(0, 8'h33);
        repeat (60) @(negedge clk);
        chk("R6", "idle-only gate blocks from idle", int'(txd), 1);
        chk("R6", "idle-only gate not complete", int'(tx_done), 0);
        cts_in = 1;
        drain();
        cfg_cts_idle_only = 0;
        send(0, 8'h44); send(0, 8'h66);
        repeat (8) @(negedge clk);
        cts_in = 0;
        repeat (80) @(negedge clk);
        cts_in = 1;
        drain();
        cfg_cts_en = 0;

        tag = "R7 R8 R9";
        cfg_rts_en = 1; cfg_rts_high = 1;
        send(0, 8'hC3); send(0, 8'h5A);
        drain();
        cfg_rts_high = 0;
        send(0, 8'h3F);
        drain();
        cfg_cts_en = 1; cts_in = 0;
        send(0, 8'h77);
        repeat (30) @(negedge clk);
        chk("R8", "rts active while waiting for CTS", int'(rts), 0);
        cts_in = 1;
        drain();
        cfg_cts_en = 0;
        cfg_rts_en = 0; cfg_rts_high = 1;
        @(negedge clk);
        chk("R9", "rts inactive when disabled", int'(rts), 0);
        send(0, 8'h99);
        drain();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule